// File: doc/BRIEF.md
# Two-Wire Register Bank Target

This block is a target (slave) on a two-wire I2C bus. It gives a bus host access to a small bank of registers. Some registers hold configuration, are writable from the bus and appear as parallel outputs. The others are read-only and mirror status inputs. The block runs entirely on an internal system clock. The SCL and SDA inputs first pass through a two-flop synchronizer and a three-tap majority vote. The block then detects clock edges, start conditions and stop conditions on the cleaned lines. It never drives SDA high: `sda_pull` is an open-drain enable, and when it is 1 the line is pulled low.

A write transfer works as follows. The host sends the device address with the direction bit clear. The first byte after that loads an 8-bit register pointer. Every further byte is stored at the pointer, and the pointer then advances. A read transfer usually follows a pointer write and a repeated start. It returns the register at the pointer, and the pointer advances after every byte that the host acknowledges. With a 50 MHz sampling clock, the filter adds about five cycles of latency, which is well inside fast-mode (400 kHz) bit timing.

The controller is a single state machine with these states:
- IDLE: released, waiting for a start.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging the address.
- PTR: shifting in the pointer byte.
- PTR_ACK: acknowledging the pointer.
- WDATA: shifting in a data byte.
- WDATA_ACK: acknowledging a data byte.
- RDATA: shifting out a data byte.
- RD_ACKCHK: released, sampling the host's acknowledge.

It moves between them as follows:
- Any state goes to ADDR on a start and to IDLE on a stop.
- ADDR goes to ADDR_ACK on a matching address and to IDLE otherwise.
- ADDR_ACK goes to RDATA for a read and to PTR for a write.
- PTR goes to PTR_ACK, and PTR_ACK goes to WDATA.
- WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA.
- RDATA goes to RD_ACKCHK.
- RD_ACKCHK goes to RDATA on an ACK and to IDLE on a NACK.

Top module: `regbank_i2c_target`

## Requirements
- R1: The block answers only the 7-bit address 0x48, which is sent in bits 7..1 of the first byte after a start. Bit 0 selects read (1) or write (0). For any other address it leaves SDA released and ignores the rest of the transfer.
- R2: Bits are taken most-significant first. Each bit is sampled once, on the rising edge of SCL. The target changes SDA only while SCL is low.
- R3: After each address, pointer or data byte that it accepts, the target pulls SDA low for the whole high phase of the ninth clock.
- R4: In a write, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments by one.
- R5: In a read, the target sends the register at the pointer and increments the pointer after each byte that the host acknowledges. A repeated start keeps the pointer.
- R6: The map is as follows:
  - Addresses 0..3 are writable configuration bytes, and byte n appears on `cfg_out[8n+7:8n]`.
  - Addresses 4..5 return `status_in` bytes 0..1.
  - Any other address reads as 0xFF.
  - Writes to the status or unmapped addresses change nothing.
- R7: If the host leaves SDA high on the acknowledge clock of a read byte, the target releases SDA and keeps it released until the next start.
- R8: A start in any state aborts the current byte and begins address reception. A stop in any state returns the block to IDLE. A partly received data byte is never stored.
- R9: While `rst_n` is low, the configuration bytes take the defaults 0xA5, 0x00, 0x0F and 0x80 (addresses 0..3), the pointer returns to 0, and SDA is released.
- R10: A pulse on SCL or SDA that lasts one sampling clock is rejected and does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_out | output | NUM_CFG*8 | Writable configuration bytes, byte 0 in the low bits |
| status_in | input | NUM_STAT*8 | Status bytes read at addresses NUM_CFG and above |

## Verification
The SCL falling edge that ends an acknowledged read byte does two things in the same cycle. It advances the pointer, and it fetches the next byte from the register bank using the advanced address. A slip in either one shows up as a shifted or repeated byte. The bench provokes this with one long acknowledged burst that crosses from configuration bytes into status bytes and then into unmapped space. A scoreboard compares every returned byte, in order, against a map the bench keeps from its own writes. The same edge also carries the load of the first bit of the next byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACKCHK
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
// Synchronizer followed by a majority vote over the last VOTE_TAPS samples.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CNT_W = $clog2(VOTE_TAPS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   tap_q;
    logic [CNT_W-1:0]       ones;
    logic                   vote;
    logic                   line_q;

    always_comb begin
        ones = '0;
        for (int i = 0; i < VOTE_TAPS; i++) begin
            ones = ones + CNT_W'(tap_q[i]);
        end
        vote = (ones > CNT_W'(VOTE_TAPS / 2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            tap_q  <= '1;
            line_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            tap_q  <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            line_q <= vote;
        end
    end

    assign line_out = line_q;

endmodule

// File: rtl/i2c_bus_events.sv
// Edge and bus-condition detection on the filtered lines.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_p;
    assign scl_fall  = ~scl_f & scl_p;
    assign start_det = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

endmodule

// File: rtl/i2c_reg_bank.sv
// Writable configuration bytes plus read mux over configuration, status and unmapped space.
module i2c_reg_bank #(
    parameter int ADDR_W   = 8,
    parameter int NUM_CFG  = 4,
    parameter int NUM_STAT = 2,
    parameter logic [NUM_CFG*8-1:0] CFG_RESET = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [NUM_STAT*8-1:0] status_in,
    output logic [NUM_CFG*8-1:0]  cfg_out,
    output logic [7:0]            rd_data
);
    logic [7:0] cfg_q [NUM_CFG];

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= CFG_RESET[g*8 +: 8];
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                cfg_q[g] <= wr_data;
            end
        end
        assign cfg_out[g*8 +: 8] = cfg_q[g];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = cfg_q[i];
        end
        for (int j = 0; j < NUM_STAT; j++) begin
            if (rd_addr == ADDR_W'(NUM_CFG + j)) rd_data = status_in[j*8 +: 8];
        end
    end

endmodule

// File: rtl/regbank_i2c_target.sv
module regbank_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int NUM_CFG  = 4,
    parameter int NUM_STAT = 2,
    parameter logic [NUM_CFG*8-1:0] CFG_RESET = 32'h800F00A5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull,
    output logic [NUM_CFG*8-1:0]  cfg_out,
    input  logic [NUM_STAT*8-1:0] status_in
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    tgt_state_e state, state_nx;

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;

    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-2:0] txreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [PTR_W-1:0]  ptr;
    logic              rw_q;
    logic              ack_seen;
    logic              pull_q;

    logic              byte_full;
    logic              addr_hit;
    logic              wr_en;
    logic [PTR_W-1:0]  rd_addr;
    logic [7:0]        rd_data;

    // Line conditioning, one filter per bus line
    i2c_line_filter #(.SYNC_STAGES(2), .VOTE_TAPS(3)) i_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_out(scl_f)
    );
    i2c_line_filter #(.SYNC_STAGES(2), .VOTE_TAPS(3)) i_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_out(sda_f)
    );

    i2c_bus_events i_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_full = (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign wr_en     = (state == ST_WDATA) && scl_fall && byte_full;
    assign rd_addr   = (state == ST_RD_ACKCHK) ? PTR_W'(ptr + 1'b1) : ptr;

    i2c_reg_bank #(
        .ADDR_W(PTR_W), .NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT), .CFG_RESET(CFG_RESET)
    ) i_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
        .rd_addr(rd_addr), .status_in(status_in),
        .cfg_out(cfg_out), .rd_data(rd_data)
    );

    // Next-state decision
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ADDR:
                    if (scl_fall && byte_full) state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:
                    if (scl_fall) state_nx = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:
                    if (scl_fall && byte_full) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:
                    if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:
                    if (scl_fall && byte_full) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK:
                    if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:
                    if (scl_fall && byte_full) state_nx = ST_RD_ACKCHK;
                ST_RD_ACKCHK:
                    if (scl_fall) state_nx = ack_seen ? ST_RDATA : ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift, pointer and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            txreg    <= '0;
            bit_cnt  <= '0;
            ptr      <= '0;
            rw_q     <= 1'b0;
            ack_seen <= 1'b0;
            pull_q   <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            pull_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && !byte_full) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_f};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && byte_full) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_hit) begin
                                pull_q <= 1'b1;
                                rw_q   <= shreg[0];
                            end
                        end else begin
                            pull_q <= 1'b1;
                        end
                        if (state == ST_PTR)   ptr <= shreg;
                        if (state == ST_WDATA) ptr <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (state == ST_ADDR_ACK && rw_q) begin
                            txreg   <= rd_data[BYTE_W-2:0];
                            pull_q  <= ~rd_data[BYTE_W-1];
                            bit_cnt <= CNT_W'(1);
                        end else begin
                            pull_q  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (byte_full) begin
                            pull_q <= 1'b0;
                        end else begin
                            pull_q  <= ~txreg[BYTE_W-2];
                            txreg   <= {txreg[BYTE_W-3:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACKCHK: begin
                    if (scl_rise) ack_seen <= ~sda_f;
                    if (scl_fall) begin
                        if (ack_seen) begin
                            ptr     <= ptr + 1'b1;
                            txreg   <= rd_data[BYTE_W-2:0];
                            pull_q  <= ~rd_data[BYTE_W-1];
                            bit_cnt <= CNT_W'(1);
                        end else begin
                            pull_q  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                end
                ST_IDLE: pull_q <= 1'b0;
                default: pull_q <= 1'b0;
            endcase
        end
    end

    assign sda_pull = pull_q;

endmodule

// File: rtl/i2c_target_checker.sv
module i2c_target_checker
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input tgt_state_e state,
    input logic       scl_f,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_pull
);
    // R1: nothing is driven while the target is not engaged
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

    // R2: the target starts pulling SDA only while SCL is low
    assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !$past(scl_f));

    // R3: acknowledge held across the high phase of the ninth clock
    assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR_ACK || state == ST_PTR_ACK || state == ST_WDATA_ACK) && scl_f)
        |-> sda_pull);

    // R7: released while the host's acknowledge is sampled
    assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACKCHK) |-> !sda_pull);

    // R8: stop returns to idle, start begins address reception
    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    assert_start_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR));

endmodule

bind regbank_i2c_target i2c_target_checker i_checker (
    .clk(clk),
    .rst_n(rst_n),
    .state(state),
    .scl_f(scl_f),
    .start_det(start_det),
    .stop_det(stop_det),
    .sda_pull(sda_pull)
);

// File: tb/test_regbank_i2c_target.sv
`timescale 1ns/1ps
module test_regbank_i2c_target;

    localparam logic [31:0] CFG_DEF  = 32'h800F00A5;
    localparam logic [15:0] STAT_VAL = 16'h5A9E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic        sda_bus;
    logic [31:0] cfg_out;
    logic [15:0] status_in = STAT_VAL;

    int total = 0;
    int fails = 0;

    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    regbank_i2c_target i_regbank_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_pull(sda_pull), .cfg_out(cfg_out), .status_in(status_in)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        sda_m = b;
        if (glitch) begin
            repeat (3) @(negedge clk);
            scl_m = 1'b1; @(negedge clk); scl_m = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            q();
        end
        scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_bus; q(); scl_m = 1'b0; q();
    endtask

    task automatic put_byte(input logic [7:0] v, input int glitch_bit, output logic acked);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) put_bit(v[i], i == glitch_bit);
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); s1 = sda_bus; q(); s2 = sda_bus;
        scl_m = 1'b0; q();
        acked = !s1 && !s2;
    endtask

    task automatic host_ack(input logic nack);
        sda_m = nack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
    endtask

    // Driver: reads one byte and posts expected and actual to the scoreboard
    task automatic rd_expect(input logic [7:0] e, input string tag, input logic nack);
        logic [7:0] v;
        logic b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            v = {v[6:0], b};
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        act_q.push_back(v);
        host_ack(nack);
    endtask

    task automatic wr_ack(input logic [7:0] v, input string tag);
        logic a;
        put_byte(v, -1, a);
        check(a, tag, {31'd0, !a}, 32'd0);
    endtask

    // Monitor: compares results in order
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(a === e, t, {24'd0, a}, {24'd0, e});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic a;
        logic b;
        repeat (5) @(negedge clk);
        // R9: reset state
        check(cfg_out === CFG_DEF, "R9 reset defaults", cfg_out, CFG_DEF);
        check(sda_pull === 1'b0, "R9 sda released in reset", {31'd0, sda_pull}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: foreign address 0x49 is ignored
        bus_start();
        put_byte({7'h49, 1'b0}, -1, a);
        check(!a, "R1 foreign address not acked", {31'd0, a}, 32'd0);
        put_byte(8'h00, -1, a);
        put_byte(8'h11, -1, a);
        check(!a, "R1 foreign data not acked", {31'd0, a}, 32'd0);
        bus_stop();
        check(cfg_out === CFG_DEF, "R1 foreign write has no effect", cfg_out, CFG_DEF);

        // R2 R3 R4: write pointer then two data bytes (0x1D is not bit-symmetric)
        bus_start();
        wr_ack({7'h48, 1'b0}, "R3 address ack");
        wr_ack(8'h01, "R3 pointer ack");
        wr_ack(8'h1D, "R3 data ack");
        wr_ack(8'hC3, "R3 second data ack");
        bus_stop();
        check(cfg_out === 32'h80C31DA5, "R4 R2 auto-increment write", cfg_out, 32'h80C31DA5);

        // R5 R6: burst read across config, status and unmapped space
        bus_start();
        wr_ack({7'h48, 1'b0}, "R5 address ack");
        wr_ack(8'h00, "R5 pointer ack");
        bus_start();
        wr_ack({7'h48, 1'b1}, "R5 read address ack");
        rd_expect(8'hA5, "R5 read reg0", 1'b0);
        rd_expect(8'h1D, "R5 read reg1", 1'b0);
        rd_expect(8'hC3, "R5 read reg2", 1'b0);
        rd_expect(8'h80, "R5 read reg3", 1'b0);
        rd_expect(8'h9E, "R6 read status0", 1'b0);
        rd_expect(8'h5A, "R6 read status1", 1'b0);
        rd_expect(8'hFF, "R6 read unmapped", 1'b1);
        bus_stop();

        // R7: after NACK the next clock sees a released line (reg5 MSB is 0)
        bus_start();
        wr_ack({7'h48, 1'b0}, "R7 address ack");
        wr_ack(8'h04, "R7 pointer ack");
        bus_start();
        wr_ack({7'h48, 1'b1}, "R7 read address ack");
        rd_expect(8'h9E, "R7 read before nack", 1'b1);
        get_bit(b);
        check(b === 1'b1, "R7 SDA released after nack", {31'd0, b}, 32'd1);
        bus_stop();

        // R6: writes to status and unmapped addresses do nothing
        bus_start();
        wr_ack({7'h48, 1'b0}, "R6 address ack");
        wr_ack(8'h04, "R6 pointer ack");
        wr_ack(8'h00, "R6 status write ack");
        bus_stop();
        bus_start();
        wr_ack({7'h48, 1'b0}, "R6 address ack");
        wr_ack(8'h20, "R6 pointer ack");
        wr_ack(8'h77, "R6 unmapped write ack");
        bus_stop();
        check(cfg_out === 32'h80C31DA5, "R6 config untouched", cfg_out, 32'h80C31DA5);
        bus_start();
        wr_ack({7'h48, 1'b0}, "R6 address ack");
        wr_ack(8'h04, "R6 pointer ack");
        bus_start();
        wr_ack({7'h48, 1'b1}, "R6 read address ack");
        rd_expect(8'h9E, "R6 status unchanged", 1'b1);
        bus_stop();

        // R8: repeated start mid-byte aborts the write, pointer kept
        bus_start();
        wr_ack({7'h48, 1'b0}, "R8 address ack");
        wr_ack(8'h02, "R8 pointer ack");
        for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
        bus_start();
        wr_ack({7'h48, 1'b1}, "R8 read address ack");
        rd_expect(8'hC3, "R8 aborted byte not stored", 1'b1);
        bus_stop();
        // R8: stop mid-byte
        bus_start();
        wr_ack({7'h48, 1'b0}, "R8 address ack");
        wr_ack(8'h03, "R8 pointer ack");
        for (int i = 0; i < 3; i++) put_bit(1'b0, 1'b0);
        bus_stop();
        check(cfg_out === 32'h80C31DA5, "R8 stop mid-byte", cfg_out, 32'h80C31DA5);

        // R10: one-cycle SCL glitch while SCL is low
        bus_start();
        wr_ack({7'h48, 1'b0}, "R10 address ack");
        wr_ack(8'h00, "R10 pointer ack");
        put_byte(8'h55, 3, a);
        check(a, "R10 ack with glitch", {31'd0, a}, 32'd1);
        bus_stop();
        check(cfg_out === 32'h80C31D55, "R10 glitch rejected", cfg_out, 32'h80C31D55);

        // R9: reset restores defaults and pointer 0
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cfg_out === CFG_DEF, "R9 defaults after reset", cfg_out, CFG_DEF);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_start();
        wr_ack({7'h48, 1'b1}, "R9 read address ack");
        rd_expect(8'hA5, "R9 pointer back at 0", 1'b1);
        bus_stop();

        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule